// File: doc/BRIEF.md
# Two-Byte Auto-Increment Program Sequencer

This block runs the word-at-a-time auto-increment programming mode of a serial flash controller. The command decoder hands it one decoded command at a time: an opcode, and for a program command an address and a 16-bit data word. The first program command opens the mode and sets the start address. The address is forced to an even word boundary. Every later program command supplies only a new data word, and the block writes it two bytes above the previous one. Each word it writes goes to the memory array through a one-cycle write strobe. An internal timer then holds the block busy for a set number of cycles.

While the mode is open, the block accepts only further program words and the leave-mode command. It refuses everything else and reports each refusal. A mode flag is kept for the status register. When enabled, a ready/busy level is presented for the serial data-out pin while chip select is high. The mode closes on the leave-mode command, or by itself after the word at the highest even address has been written and its busy time has run out. Words at or above a protection floor are skipped without a write, but the address still advances.

Top module: `aai_word_seq`

States of the controller: `ST_BYTE` (mode closed), `ST_AAI_RDY` (mode open, no program running), `ST_AAI_BUSY` (mode open, word being programmed), `ST_EXIT` (last word at top of space being programmed; mode closes when done). Transitions:
- `ST_BYTE` to `ST_AAI_BUSY`, `ST_AAI_RDY` or `ST_EXIT` on an accepted first program command. The target depends on whether the word is protected or at the top of the space.
- `ST_AAI_RDY` or `ST_AAI_BUSY` to the same three targets on an accepted follow-on word.
- `ST_AAI_BUSY` to `ST_AAI_RDY` when the timer ends.
- Any mode state to `ST_BYTE` on leave-mode.
- `ST_EXIT` to `ST_BYTE` when the timer ends.

## Requirements
- R1: After reset `aai_mode`, `busy`, `wr_en`, `so_oe`, `cmd_ack` and `cmd_nak` are all 0. Acknowledge and refusal are never both 1.
- R2: Opcode encoding on `cmd_op`: 1 = program word, 2 = leave mode, 3 = ready/busy on data-out enable, 4 = ready/busy on data-out disable; all other values are foreign commands.
- R3: A program command accepted with the mode closed sets `aai_mode` and writes `cmd_word` at `cmd_addr` with bit 0 cleared. One clock edge after the command is sampled, `wr_en`, `cmd_ack` and `busy` read 1.
- R4: Each accepted follow-on program command writes at the previous word address plus 2. The command's address field is ignored.
- R5: While the mode is open, any opcode other than 1 or 2 is refused (`cmd_nak`=1) and causes no write and no change of the ready/busy enable.
- R6: A program command that arrives while `busy` is 1 is refused and causes no write. `busy` stays 1 for `BUSY_CYC` cycles after a write.
- R7: Opcode 2 clears `aai_mode` on the next edge, even while busy. The running program time is not cut short.
- R8: With ready/busy enabled, `so_oe` is 1 only while the mode is open and `cs_n` is 1. `so_out` is then 0 while busy and 1 when ready. Opcodes 3 and 4 take effect only with the mode closed.
- R9: A word whose address is at or above `lock_floor` is acknowledged but not written and starts no busy time. The address still advances by 2.
- R10: After the word at the highest even address is written, `aai_mode` stays 1 until the busy time ends and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| cmd_valid | input | 1 | One-cycle strobe: decoded command present |
| cmd_op | input | 3 | Decoded opcode (see R2) |
| cmd_addr | input | ADDR_W | Start address, used by the first program command only |
| cmd_word | input | 16 | Data word of a program command |
| lock_floor | input | ADDR_W | Lowest protected address |
| aai_mode | output | 1 | Auto-increment mode flag |
| busy | output | 1 | Program timer running |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | ADDR_W | Array word address (even) |
| wr_data | output | 16 | Array write data |
| cmd_ack | output | 1 | Command acted on |
| cmd_nak | output | 1 | Command refused |
| so_oe | output | 1 | Drive ready/busy level on data-out |
| so_out | output | 1 | Ready/busy level: 1 ready, 0 busy |

## Verification
The program path is tried in several ways:
- An odd start address, which must be rounded down.
- Follow-on words at the same pace as the timer, which checks the +2 stride.
- Words issued during busy time, which tells refusal apart from silent loss.
- Words crossing the protection floor, which shows that skipping advances the address without a write or a busy period.

A start just below the top of the space separates the automatic close after the busy time from a close at the write itself. Leave-mode while busy shows that the flag and the timer are independent. Ready/busy is checked with chip select in both states and with the enable off, and foreign opcodes are sent during the mode to show they change nothing.

// File: rtl/aai_pkg.sv
package aai_pkg;
    localparam logic [2:0] OP_PROG   = 3'd1;
    localparam logic [2:0] OP_LEAVE  = 3'd2;
    localparam logic [2:0] OP_RB_ON  = 3'd3;
    localparam logic [2:0] OP_RB_OFF = 3'd4;

    typedef enum logic [1:0] {
        ST_BYTE     = 2'd0,
        ST_AAI_RDY  = 2'd1,
        ST_AAI_BUSY = 2'd2,
        ST_EXIT     = 2'd3
    } seq_state_e;
endpackage

// File: rtl/aai_busy_timer.sv
module aai_busy_timer #(
    parameter int BUSY_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = (BUSY_CYC < 2) ? 1 : $clog2(BUSY_CYC + 1);

    generate
        if (BUSY_CYC == 0) begin : g_none
            assign busy = 1'b0;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (load) begin
                    cnt_q <= CNT_W'(BUSY_CYC);
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            assign busy = (cnt_q != '0);
        end
    endgenerate
endmodule

// File: rtl/aai_addr_unit.sv
module aai_addr_unit #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] lock_floor,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              is_top,
    output logic              is_prot
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(2);

    logic [ADDR_W-1:0] next_q;

    always_comb begin
        if (load) cur_addr = {start_addr[ADDR_W-1:1], 1'b0};
        else      cur_addr = next_q;
        is_top  = &cur_addr[ADDR_W-1:1];
        is_prot = (cur_addr >= lock_floor);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
        end else if (load || step) begin
            next_q <= cur_addr + STRIDE;
        end
    end
endmodule

// File: rtl/aai_ctrl.sv
module aai_ctrl
    import aai_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [15:0]       cmd_word,
    input  logic              busy,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              is_top,
    input  logic              is_prot,
    output logic              addr_load,
    output logic              addr_step,
    output logic              tmr_load,
    output logic              aai_mode,
    output logic              rb_en,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    output logic              cmd_ack,
    output logic              cmd_nak
);
    seq_state_e state_q, state_d;

    logic is_prog, is_leave, is_rb_on, is_rb_off;
    logic in_mode, accept, ack_d, nak_d;
    seq_state_e after_word;

    always_comb begin
        is_prog   = cmd_valid && (cmd_op == OP_PROG);
        is_leave  = cmd_valid && (cmd_op == OP_LEAVE);
        is_rb_on  = cmd_valid && (cmd_op == OP_RB_ON);
        is_rb_off = cmd_valid && (cmd_op == OP_RB_OFF);
        in_mode   = (state_q != ST_BYTE);
        accept    = is_prog && !busy && (state_q != ST_EXIT);
        addr_load = accept && !in_mode;
        addr_step = accept && in_mode;
        tmr_load  = accept && !is_prot;

        if (is_top) after_word = is_prot ? ST_BYTE : ST_EXIT;
        else        after_word = is_prot ? ST_AAI_RDY : ST_AAI_BUSY;

        state_d = state_q;
        unique case (state_q)
            ST_BYTE: begin
                if (accept) state_d = after_word;
            end
            ST_AAI_RDY, ST_AAI_BUSY: begin
                if (is_leave)                            state_d = ST_BYTE;
                else if (accept)                         state_d = after_word;
                else if (state_q == ST_AAI_BUSY && !busy) state_d = ST_AAI_RDY;
            end
            ST_EXIT: begin
                if (is_leave || !busy) state_d = ST_BYTE;
            end
        endcase

        ack_d = accept || is_leave || (!in_mode && (is_rb_on || is_rb_off));
        nak_d = cmd_valid && !ack_d && (in_mode || is_prog);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BYTE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_en   <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            cmd_ack <= 1'b0;
            cmd_nak <= 1'b0;
        end else begin
            wr_en   <= tmr_load;
            cmd_ack <= ack_d;
            cmd_nak <= nak_d;
            if (tmr_load) begin
                wr_addr <= cur_addr;
                wr_data <= cmd_word;
            end
            if (!in_mode && is_rb_on)  rb_en <= 1'b1;
            if (!in_mode && is_rb_off) rb_en <= 1'b0;
        end
    end

    assign aai_mode = (state_q != ST_BYTE);
endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq #(
    parameter int ADDR_W   = 19,
    parameter int BUSY_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [15:0]       cmd_word,
    input  logic [ADDR_W-1:0] lock_floor,
    output logic              aai_mode,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    output logic              cmd_ack,
    output logic              cmd_nak,
    output logic              so_oe,
    output logic              so_out
);
    logic              addr_load, addr_step, tmr_load, rb_en;
    logic [ADDR_W-1:0] cur_addr;
    logic              is_top, is_prot;

    aai_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .busy  (busy)
    );

    aai_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (addr_load),
        .step       (addr_step),
        .start_addr (cmd_addr),
        .lock_floor (lock_floor),
        .cur_addr   (cur_addr),
        .is_top     (is_top),
        .is_prot    (is_prot)
    );

    aai_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_word  (cmd_word),
        .busy      (busy),
        .cur_addr  (cur_addr),
        .is_top    (is_top),
        .is_prot   (is_prot),
        .addr_load (addr_load),
        .addr_step (addr_step),
        .tmr_load  (tmr_load),
        .aai_mode  (aai_mode),
        .rb_en     (rb_en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cmd_ack   (cmd_ack),
        .cmd_nak   (cmd_nak)
    );

    assign so_oe  = rb_en && aai_mode && cs_n;
    assign so_out = !busy;
endmodule

// File: rtl/aai_word_seq_chk.sv
module aai_word_seq_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              aai_mode,
    input logic              busy,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              cmd_ack,
    input logic              cmd_nak,
    input logic              so_oe
);
    a_r1_ack_nak_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ack && cmd_nak));

    a_r3_write_even: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[0] == 1'b0) && aai_mode && busy && cmd_ack);

    a_r6_no_write_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && busy) |=> (!wr_en && cmd_nak));

    a_r5_nak_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_nak |-> !wr_en);

    a_r7_leave_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2) |=> (!aai_mode && cmd_ack));

    a_r8_so_gated: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (cs_n && aai_mode));
endmodule

bind aai_word_seq aai_word_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .aai_mode  (aai_mode),
    .busy      (busy),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .cmd_ack   (cmd_ack),
    .cmd_nak   (cmd_nak),
    .so_oe     (so_oe)
);

// File: tb/aai_word_seq_bench.sv
module aai_word_seq_bench;
    localparam int AW = 19;
    localparam int BC = 6;
    localparam logic [AW-1:0] NOLOCK = '1;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0, lock_floor = NOLOCK, wr_addr;
    logic [15:0] cmd_word = '0, wr_data;
    logic aai_mode, busy, wr_en, cmd_ack, cmd_nak, so_oe, so_out;
    int total = 0, bad = 0, cyc = 0;

    always #4 clk = ~clk;

    aai_word_seq #(.ADDR_W(AW), .BUSY_CYC(BC)) u_aai_word_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_word(cmd_word),
        .lock_floor(lock_floor), .aai_mode(aai_mode), .busy(busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_ack(cmd_ack), .cmd_nak(cmd_nak), .so_oe(so_oe), .so_out(so_out));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            total++; bad++;
            $display("FAIL watchdog: got=%0d expected=<20000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_word = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 mode", aai_mode, 0);
        check("R1 busy", busy, 0);
        check("R1 wr_en", wr_en, 0);
        check("R1 so_oe", so_oe, 0);
        check("R1 ack/nak", {cmd_ack, cmd_nak}, 0);
    endtask

    task automatic t_first_and_stride;
        issue(3'd1, 19'h00101, 16'hA5A5);
        check("R3 wr_en", wr_en, 1);
        check("R3 addr even", wr_addr, 19'h00100);
        check("R3 data", wr_data, 16'hA5A5);
        check("R3 mode/ack/busy", {aai_mode, cmd_ack, busy}, 3'b111);
        issue(3'd1, 19'h0, 16'h1111);
        check("R6 refused while busy", {cmd_nak, wr_en}, 2'b10);
        wait_cyc(BC - 1);
        check("R6 busy done", busy, 0);
        issue(3'd1, 19'h05555, 16'h2222);
        check("R4 stride addr", wr_addr, 19'h00102);
        check("R4 data", {wr_en, wr_data}, {1'b1, 16'h2222});
        wait_cyc(BC);
        issue(3'd1, 19'h0, 16'h3333);
        check("R4 second stride", wr_addr, 19'h00104);
        wait_cyc(BC);
    endtask

    task automatic t_foreign_in_mode;
        issue(3'd6, 19'h0, 16'h0);
        check("R5 foreign nak", {cmd_nak, wr_en, aai_mode}, 3'b101);
        issue(3'd3, 19'h0, 16'h0);
        check("R5 rb_on refused", {cmd_nak, so_oe}, 2'b10);
        issue(3'd0, 19'h0, 16'h0);
        check("R2 code 0 foreign", cmd_nak, 1);
    endtask

    task automatic t_leave_busy;
        issue(3'd1, 19'h0, 16'h4444);
        check("R7 write before leave", wr_addr, 19'h00106);
        issue(3'd2, 19'h0, 16'h0);
        check("R7 leave clears mode", {aai_mode, cmd_ack}, 2'b01);
        check("R7 busy continues", busy, 1);
        issue(3'd1, 19'h00200, 16'h0);
        check("R6 closed-mode busy nak", {cmd_nak, wr_en, aai_mode}, 3'b100);
        wait_cyc(BC);
        check("R7 mode stays closed", aai_mode, 0);
    endtask

    task automatic t_ready_busy;
        issue(3'd3, 19'h0, 16'h0);
        check("R8 rb_on ack", cmd_ack, 1);
        check("R8 no drive outside mode", so_oe, 0);
        issue(3'd1, 19'h00300, 16'h5555);
        check("R8 drives busy low", {so_oe, so_out}, 2'b10);
        wait_cyc(BC);
        check("R8 drives ready high", {so_oe, so_out}, 2'b11);
        cs_n = 1'b0; #1;
        check("R8 no drive with cs low", so_oe, 0);
        cs_n = 1'b1;
        issue(3'd2, 19'h0, 16'h0);
        issue(3'd4, 19'h0, 16'h0);
        issue(3'd1, 19'h00300, 16'h5555);
        check("R8 disabled", {aai_mode, so_oe}, 2'b10);
        wait_cyc(BC);
        issue(3'd2, 19'h0, 16'h0);
    endtask

    task automatic t_protect;
        lock_floor = 19'h00200;
        issue(3'd1, 19'h001FE, 16'h6666);
        check("R9 below floor written", {wr_en, wr_addr}, {1'b1, 19'h001FE});
        wait_cyc(BC);
        issue(3'd1, 19'h0, 16'h7777);
        check("R9 protected skipped", {cmd_ack, wr_en, busy}, 3'b100);
        issue(3'd1, 19'h0, 16'h7777);
        check("R9 second skip", {cmd_ack, wr_en}, 2'b10);
        lock_floor = NOLOCK;
        issue(3'd1, 19'h0, 16'h8888);
        check("R9 address advanced past skips", {wr_en, wr_addr}, {1'b1, 19'h00204});
        wait_cyc(BC);
        issue(3'd2, 19'h0, 16'h0);
    endtask

    task automatic t_top;
        issue(3'd1, 19'h7FFFD, 16'h9999);
        check("R10 near top", wr_addr, 19'h7FFFC);
        wait_cyc(BC);
        issue(3'd1, 19'h0, 16'hAAAA);
        check("R10 top word", {wr_en, wr_addr}, {1'b1, 19'h7FFFE});
        issue(3'd1, 19'h0, 16'hBBBB);
        check("R10 no wrap write", {wr_en, cmd_nak}, 2'b01);
        wait_cyc(BC - 2);
        check("R10 mode held while busy", aai_mode, 1);
        wait_cyc(1);
        check("R10 mode closed", aai_mode, 0);
    endtask

    initial begin
        wait_cyc(3);
        t_reset;
        rst_n = 1'b1;
        t_first_and_stride;
        t_foreign_in_mode;
        t_leave_busy;
        t_ready_busy;
        t_protect;
        t_top;
        wait_cyc(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule